// File: doc/BRIEF.md
# Modem Frame Transmit Sequencer

This block is the host-side controller that sends one complete frame through a 4-level FSK modem by driving the modem's register port. On a start pulse it programs the modem's mode and control registers. It reads status once to confirm that the data buffer is free. It then loads each frame section into the modem's data buffer, one byte per write strobe. After each section it writes the transmit task code for that section to the command register.

Between sections the sequencer waits for the active-low modem interrupt and reads status. It advances only when the handshake bits are correct. An interrupt raised by the symbol-ready flag is recognised and skipped. After the last block it waits for one more interrupt, which must report an empty input buffer. It then counts 18 symbol ticks so that the final symbol has left the pulse-shaping filter, and raises `done`. Any status check that fails raises `error`, stores a code naming the stage, and returns the sequencer to idle.

Top module: `frameTxSeq`

## Requirements
- R1: After start, the first two register writes are the mode register (address 2) and then the control register (address 3). The mode byte has bit 7 (interrupt enable) = 1, bit 6 (transmit select) = 1, bit 5 (eye output) = 0, bit 4 (power save) = 0, bit 3 = cfgSymIrq, bit 2 = cfgInvert and all other bits 0. The control byte equals cfgClkDiv.
- R2: Before the first buffer write, the status register (address 4) is read once. If its buffer-free flag is 0, the frame aborts with error code 1.
- R3: Sections are written in this order: 6 preamble bytes, 6 frame-sync bytes, 3 station-ID bytes, 10 header bytes, the intermediate blocks of 12 bytes each, and 8 last-block bytes. Each byte is one write to address 0, taken from byteData with one srcPop per byte in source order.
- R4: Each section ends with one command write (address 1) carrying its task code: 0x01 for both sync sections, 0x02 for station ID, 0x03 for header, 0x04 for an intermediate block and 0x05 for the last block. A command write never occurs in the cycle directly after a buffer write.
- R5: The number of intermediate blocks equals numInter, from 0 to 255.
- R6: After each command write the sequencer waits for irqN low and then reads status. The status flags on regRdata are bit 3 IRQ, bit 2 buffer-free, bit 1 input-buffer-empty and bit 0 symbol-ready. The next section starts only when IRQ=1, buffer-free=1 and input-buffer-empty=0.
- R7: A status read with symbol-ready=1 and buffer-free=0 is ignored. The sequencer waits for the next interrupt without advancing and without flagging an error.
- R8: After the last-block handshake, a further interrupt is awaited. Its status must show IRQ, buffer-free and input-buffer-empty all 1, otherwise the frame aborts with error code 8.
- R9: `done` rises on the clock edge that samples the 18th symTick after the final status read, and holds until the next start.
- R10: A failed section check aborts the frame with these error codes: 2 = preamble, 3 = frame sync, 4 = station ID, 5 = header, 6 = intermediate, 7 = last. `error` stays 1 with no further bus activity until the next start, which clears it.
- R11: After reset regWr, regRd, srcPop, done and error are 0 and errCode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a frame while idle |
| cfgClkDiv | input | 8 | Value written to the modem control register |
| cfgInvert | input | 1 | Symbol inversion bit for the mode register |
| cfgSymIrq | input | 1 | Sync-symbol interrupt enable for the mode register |
| numInter | input | 8 | Number of intermediate blocks in the frame |
| byteData | input | 8 | Current payload byte from the local source |
| srcPop | output | 1 | Consumes the current payload byte |
| irqN | input | 1 | Modem interrupt, active low |
| symTick | input | 1 | One pulse per transmitted symbol |
| regRdata | input | 4 | Status flags read back: IRQ, buffer-free, input-empty, symbol-ready |
| regAddr | output | 3 | Modem register address |
| regWdata | output | 8 | Modem register write data |
| regWr | output | 1 | Register write strobe |
| regRd | output | 1 | Register read strobe |
| done | output | 1 | Frame fully transmitted |
| error | output | 1 | Frame aborted on a failed status check |
| errCode | output | 4 | Stage that failed |

## Verification
The bench targets three kinds of fault. First, section-count corners: zero intermediate blocks, a single block, and the full 255. A wrong count or order shows up as a misplaced task code or a byte stream that drifts from the source order. Second, the modem model inserts symbol-ready interrupts ahead of every real acknowledge. A design that does not tell them apart either aborts or skips a section. Third, faulty acknowledges are injected at chosen stages, in the final drain status and in the preflight read. Each must give the exact stage code, and the bus must stay quiet afterwards. The drain count is checked to the exact tick, so a design that starts counting one tick early or late is caught.

// File: rtl/frameTxPkg.sv
package frameTxPkg;
  localparam int ADDR_W = 3;

  // modem register addresses
  localparam logic [ADDR_W-1:0] A_BUF  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  // transmit task codes
  localparam logic [7:0] T_RAW24 = 8'h01;
  localparam logic [7:0] T_SID   = 8'h02;
  localparam logic [7:0] T_HDR   = 8'h03;
  localparam logic [7:0] T_INT   = 8'h04;
  localparam logic [7:0] T_LAST  = 8'h05;

  // status flag positions on the 4-bit read bus
  localparam int ST_W     = 4;
  localparam int ST_IRQ   = 3;
  localparam int ST_FREE  = 2;
  localparam int ST_EMPTY = 1;
  localparam int ST_SYM   = 0;

  // mode byte bit positions
  localparam int MD_IRQEN  = 7;
  localparam int MD_TXSEL  = 6;
  localparam int MD_EYE    = 5;
  localparam int MD_PSAVE  = 4;
  localparam int MD_SYMIRQ = 3;
  localparam int MD_INV    = 2;

  typedef enum logic [2:0] {
    SEC_SSYNC, SEC_FSYNC, SEC_SID, SEC_HDR, SEC_INT, SEC_LAST
  } secT;

  typedef struct packed {
    logic frameInit;
    logic byteLoad;
    logic byteStep;
    logic secNext;
    logic drainClr;
    logic drainRun;
  } dpCtlT;
endpackage

// File: rtl/frameTxPath.sv
module frameTxPath
  import frameTxPkg::*;
#(
  parameter int SYNC_BYTES  = 6,
  parameter int FSYNC_BYTES = 6,
  parameter int SID_BYTES   = 3,
  parameter int HDR_BYTES   = 10,
  parameter int INT_BYTES   = 12,
  parameter int LAST_BYTES  = 8,
  parameter int INT_CNT_W   = 8,
  parameter int LEAD_SYMS   = 2,
  parameter int FLUSH_SYMS  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtlT                ctl,
  input  logic [INT_CNT_W-1:0] numInter,
  input  logic                 symTick,
  output secT                  sec,
  output logic                 lastByte,
  output logic [7:0]           taskCode,
  output logic                 isLastSec,
  output logic                 drainDone
);
  localparam int DRAIN_SYMS = LEAD_SYMS + FLUSH_SYMS;
  localparam int CNT_W = $clog2(SYNC_BYTES + FSYNC_BYTES + SID_BYTES + HDR_BYTES
                                + INT_BYTES + LAST_BYTES + 1);
  localparam int DRN_W = $clog2(DRAIN_SYMS + 1);

  secT                  secQ;
  logic [CNT_W-1:0]     byteCnt;
  logic [INT_CNT_W-1:0] interLeft;
  logic [DRN_W-1:0]     drainCnt;

  function automatic logic [CNT_W-1:0] secLen(input secT s);
    case (s)
      SEC_SSYNC: return CNT_W'(SYNC_BYTES);
      SEC_FSYNC: return CNT_W'(FSYNC_BYTES);
      SEC_SID:   return CNT_W'(SID_BYTES);
      SEC_HDR:   return CNT_W'(HDR_BYTES);
      SEC_INT:   return CNT_W'(INT_BYTES);
      default:   return CNT_W'(LAST_BYTES);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ      <= SEC_SSYNC;
      interLeft <= '0;
      byteCnt   <= '0;
      drainCnt  <= '0;
    end else begin
      if (ctl.frameInit) begin
        secQ      <= SEC_SSYNC;
        interLeft <= numInter;
      end else if (ctl.secNext) begin
        case (secQ)
          SEC_SSYNC: secQ <= SEC_FSYNC;
          SEC_FSYNC: secQ <= SEC_SID;
          SEC_SID:   secQ <= SEC_HDR;
          SEC_HDR:   secQ <= (interLeft == '0) ? SEC_LAST : SEC_INT;
          SEC_INT: begin
            interLeft <= interLeft - 1'b1;
            if (interLeft == INT_CNT_W'(1)) secQ <= SEC_LAST;
          end
          default: secQ <= secQ;
        endcase
      end
      if (ctl.byteLoad)      byteCnt <= secLen(secQ) - 1'b1;
      else if (ctl.byteStep) byteCnt <= byteCnt - 1'b1;
      if (ctl.drainClr)                 drainCnt <= '0;
      else if (ctl.drainRun && symTick) drainCnt <= drainCnt + 1'b1;
    end
  end

  always_comb begin
    case (secQ)
      SEC_SSYNC, SEC_FSYNC: taskCode = T_RAW24;
      SEC_SID:              taskCode = T_SID;
      SEC_HDR:              taskCode = T_HDR;
      SEC_INT:              taskCode = T_INT;
      default:              taskCode = T_LAST;
    endcase
  end

  assign sec       = secQ;
  assign lastByte  = (byteCnt == '0);
  assign isLastSec = (secQ == SEC_LAST);
  assign drainDone = ctl.drainRun && symTick && (drainCnt == DRN_W'(DRAIN_SYMS - 1));

  // R9
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainCnt <= DRN_W'(DRAIN_SYMS));

  // R5
  inter_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.frameInit && !ctl.secNext) |=> $stable(interLeft));
endmodule

// File: rtl/frameTxCtrl.sv
module frameTxCtrl
  import frameTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] cfgClkDiv,
  input  logic              cfgInvert,
  input  logic              cfgSymIrq,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ST_W-1:0]   regRdata,
  input  logic              irqN,
  input  secT               sec,
  input  logic              lastByte,
  input  logic [7:0]        taskCode,
  input  logic              isLastSec,
  input  logic              drainDone,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWr,
  output logic              regRd,
  output logic              srcPop,
  output logic              done,
  output logic              error,
  output logic [3:0]        errCode,
  output dpCtlT             ctl
);
  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_CTRL, S_PRE, S_PREP, S_LOAD, S_GAP, S_CMD,
    S_WIRQ, S_CHK, S_WFIN, S_CHKFIN, S_DRAIN
  } stT;

  stT               st, nxt;
  logic             doneQ, errQ;
  logic [3:0]       codeQ, failCode;
  logic             failNow, finishNow;
  logic [DATA_W-1:0] modeVal;
  logic             stIrq, stFree, stEmpty, stSymOnly;

  assign stIrq     = regRdata[ST_IRQ];
  assign stFree    = regRdata[ST_FREE];
  assign stEmpty   = regRdata[ST_EMPTY];
  assign stSymOnly = regRdata[ST_SYM] && !regRdata[ST_FREE];

  always_comb begin
    modeVal            = '0;
    modeVal[MD_IRQEN]  = 1'b1;
    modeVal[MD_TXSEL]  = 1'b1;
    modeVal[MD_EYE]    = 1'b0;
    modeVal[MD_PSAVE]  = 1'b0;
    modeVal[MD_SYMIRQ] = cfgSymIrq;
    modeVal[MD_INV]    = cfgInvert;
  end

  always_comb begin
    nxt       = st;
    ctl       = '0;
    regWr     = 1'b0;
    regRd     = 1'b0;
    regAddr   = A_BUF;
    regWdata  = '0;
    srcPop    = 1'b0;
    failNow   = 1'b0;
    failCode  = 4'd0;
    finishNow = 1'b0;
    case (st)
      S_IDLE: if (start) begin ctl.frameInit = 1'b1; nxt = S_MODE; end
      S_MODE: begin regWr = 1'b1; regAddr = A_MODE; regWdata = modeVal; nxt = S_CTRL; end
      S_CTRL: begin regWr = 1'b1; regAddr = A_CTRL; regWdata = cfgClkDiv; nxt = S_PRE; end
      S_PRE: begin
        regRd = 1'b1; regAddr = A_STAT;
        if (stFree) nxt = S_PREP;
        else begin failNow = 1'b1; failCode = 4'd1; nxt = S_IDLE; end
      end
      S_PREP: begin ctl.byteLoad = 1'b1; nxt = S_LOAD; end
      S_LOAD: begin
        regWr = 1'b1; regAddr = A_BUF; regWdata = byteData; srcPop = 1'b1;
        ctl.byteStep = 1'b1;
        if (lastByte) nxt = S_GAP;
      end
      S_GAP: nxt = S_CMD;
      S_CMD: begin regWr = 1'b1; regAddr = A_CMD; regWdata = DATA_W'(taskCode); nxt = S_WIRQ; end
      S_WIRQ: if (!irqN) nxt = S_CHK;
      S_CHK: begin
        regRd = 1'b1; regAddr = A_STAT;
        if (stSymOnly) nxt = S_WIRQ;
        else if (stIrq && stFree && !stEmpty) begin
          ctl.secNext = !isLastSec;
          nxt = isLastSec ? S_WFIN : S_PREP;
        end else begin
          failNow = 1'b1; failCode = 4'(sec) + 4'd2; nxt = S_IDLE;
        end
      end
      S_WFIN: if (!irqN) nxt = S_CHKFIN;
      S_CHKFIN: begin
        regRd = 1'b1; regAddr = A_STAT;
        if (stSymOnly) nxt = S_WFIN;
        else if (stIrq && stFree && stEmpty) begin ctl.drainClr = 1'b1; nxt = S_DRAIN; end
        else begin failNow = 1'b1; failCode = 4'd8; nxt = S_IDLE; end
      end
      S_DRAIN: begin
        ctl.drainRun = 1'b1;
        if (drainDone) begin finishNow = 1'b1; nxt = S_IDLE; end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      codeQ <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) begin
        doneQ <= 1'b0;
        errQ  <= 1'b0;
        codeQ <= '0;
      end
      if (failNow) begin
        errQ  <= 1'b1;
        codeQ <= failCode;
      end
      if (finishNow) doneQ <= 1'b1;
    end
  end

  assign done    = doneQ;
  assign error   = errQ;
  assign errCode = codeQ;

  // R4
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_BUF) |=> !(regWr && regAddr == A_CMD));

  // R11
  no_rdwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && errQ));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !start) |-> (!regWr && !regRd && !srcPop));

  // R3
  pop_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcPop |-> (regWr && regAddr == A_BUF));
endmodule

// File: rtl/frameTxSeq.sv
module frameTxSeq
  import frameTxPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int INT_CNT_W   = 8,
  parameter int SYNC_BYTES  = 6,
  parameter int FSYNC_BYTES = 6,
  parameter int SID_BYTES   = 3,
  parameter int HDR_BYTES   = 10,
  parameter int INT_BYTES   = 12,
  parameter int LAST_BYTES  = 8,
  parameter int LEAD_SYMS   = 2,
  parameter int FLUSH_SYMS  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [DATA_W-1:0]    cfgClkDiv,
  input  logic                 cfgInvert,
  input  logic                 cfgSymIrq,
  input  logic [INT_CNT_W-1:0] numInter,
  input  logic [DATA_W-1:0]    byteData,
  output logic                 srcPop,
  input  logic                 irqN,
  input  logic                 symTick,
  input  logic [3:0]           regRdata,
  output logic [2:0]           regAddr,
  output logic [DATA_W-1:0]    regWdata,
  output logic                 regWr,
  output logic                 regRd,
  output logic                 done,
  output logic                 error,
  output logic [3:0]           errCode
);
  dpCtlT      ctl;
  secT        sec;
  logic       lastByte, isLastSec, drainDone;
  logic [7:0] taskCode;

  frameTxPath #(
    .SYNC_BYTES(SYNC_BYTES), .FSYNC_BYTES(FSYNC_BYTES), .SID_BYTES(SID_BYTES),
    .HDR_BYTES(HDR_BYTES), .INT_BYTES(INT_BYTES), .LAST_BYTES(LAST_BYTES),
    .INT_CNT_W(INT_CNT_W), .LEAD_SYMS(LEAD_SYMS), .FLUSH_SYMS(FLUSH_SYMS)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .numInter(numInter), .symTick(symTick),
    .sec(sec), .lastByte(lastByte), .taskCode(taskCode), .isLastSec(isLastSec),
    .drainDone(drainDone)
  );

  frameTxCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgClkDiv(cfgClkDiv),
    .cfgInvert(cfgInvert), .cfgSymIrq(cfgSymIrq), .byteData(byteData),
    .regRdata(regRdata), .irqN(irqN), .sec(sec), .lastByte(lastByte),
    .taskCode(taskCode), .isLastSec(isLastSec), .drainDone(drainDone),
    .regAddr(regAddr), .regWdata(regWdata), .regWr(regWr), .regRd(regRd),
    .srcPop(srcPop), .done(done), .error(error), .errCode(errCode), .ctl(ctl)
  );
endmodule

// File: tb/frameTxSeq_bench.sv
`timescale 1ns/1ps
module frameTxSeq_bench;
  import frameTxPkg::*;

  typedef logic [10:0] busEntT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cfgClkDiv = 8'd0;
  logic       cfgInvert = 1'b0;
  logic       cfgSymIrq = 1'b0;
  logic [7:0] numInter = 8'd0;
  logic [7:0] byteData;
  logic       srcPop;
  logic       irqN;
  logic       symTick;
  logic [3:0] regRdata;
  logic [2:0] regAddr;
  logic [7:0] regWdata;
  logic       regWr, regRd, done, error;
  logic [3:0] errCode;

  // modem model controls
  logic       mdlClr = 1'b0;
  logic [3:0] idleStat = 4'b0100;
  logic       injSym = 1'b0;
  logic       finBad = 1'b0;
  int         errAt = -1;
  logic [7:0] payBase = 8'd0;

  // modem model state
  logic [3:0] statVal;
  int         cd, ackIdx, popCnt, gapViol, tickCnt, tickPh;
  logic       symPend, finPend, inFinal, tickCounting, prevBufWr;
  busEntT     logQ[$];
  busEntT     expQ[$];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  frameTxSeq u_frameTxSeq (
    .clk(clk), .rstN(rstN), .start(start), .cfgClkDiv(cfgClkDiv),
    .cfgInvert(cfgInvert), .cfgSymIrq(cfgSymIrq), .numInter(numInter),
    .byteData(byteData), .srcPop(srcPop), .irqN(irqN), .symTick(symTick),
    .regRdata(regRdata), .regAddr(regAddr), .regWdata(regWdata), .regWr(regWr),
    .regRd(regRd), .done(done), .error(error), .errCode(errCode)
  );

  function automatic logic [7:0] payByte(input logic [7:0] base, input int idx);
    return 8'(int'(base) + idx * 29 + (idx >> 3));
  endfunction

  assign byteData = payByte(payBase, popCnt);
  assign regRdata = statVal;

  // symbol tick every third cycle
  always @(posedge clk) begin
    if (!rstN) begin tickPh <= 0; symTick <= 1'b0; end
    else begin
      tickPh  <= (tickPh == 2) ? 0 : tickPh + 1;
      symTick <= (tickPh == 2);
    end
  end

  // modem register model and bus log
  always @(posedge clk) begin
    if (!rstN || mdlClr) begin
      irqN <= 1'b1; statVal <= idleStat; cd <= 0; ackIdx <= 0; popCnt <= 0;
      gapViol <= 0; tickCnt <= 0; tickCounting <= 1'b0; symPend <= 1'b0;
      finPend <= 1'b0; inFinal <= 1'b0; prevBufWr <= 1'b0;
      logQ.delete();
    end else begin
      if (regWr) logQ.push_back({regAddr, regWdata});
      if (regWr && regAddr == A_CMD && prevBufWr) gapViol <= gapViol + 1;
      prevBufWr <= regWr && regAddr == A_BUF;
      if (srcPop) popCnt <= popCnt + 1;
      if (tickCounting && symTick) tickCnt <= tickCnt + 1;

      if (regWr && regAddr == A_CMD) begin
        cd      <= 2 + $urandom_range(0, 4);
        symPend <= injSym;
        finPend <= (regWdata == T_LAST);
      end else if (cd == 1) begin
        cd   <= 0;
        irqN <= 1'b0;
        if (symPend)      statVal <= 4'b1001;
        else if (inFinal) statVal <= finBad ? 4'b1100 : 4'b1110;
        else              statVal <= (ackIdx == errAt) ? 4'b1000 : 4'b1100;
      end else if (cd > 1) cd <= cd - 1;

      if (regRd && regAddr == A_STAT && !irqN) begin
        irqN <= 1'b1;
        if (statVal == 4'b1001) begin
          symPend <= 1'b0;
          cd <= 3;
        end else if (inFinal) begin
          inFinal <= 1'b0;
          tickCounting <= 1'b1;
          tickCnt <= 0;
        end else begin
          ackIdx <= ackIdx + 1;
          if (finPend) begin finPend <= 1'b0; inFinal <= 1'b1; cd <= 4; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] modeFor(input bit inv, input bit sym);
    logic [7:0] m;
    m = 8'h00;
    m[7] = 1'b1; m[6] = 1'b1; m[3] = sym; m[2] = inv;
    return m;
  endfunction

  function automatic int codeFor(input int k, input int nInt);
    if (k < 4) return k + 2;
    if (k < 4 + nInt) return 6;
    return 7;
  endfunction

  task automatic buildExp(input int nInt, input bit inv, input bit sym,
                          input logic [7:0] div, input logic [7:0] base);
    int idx;
    int lens[$];
    logic [7:0] tasks[$];
    expQ.delete();
    expQ.push_back({A_MODE, modeFor(inv, sym)});
    expQ.push_back({A_CTRL, div});
    lens = '{6, 6, 3, 10};
    tasks = '{8'h01, 8'h01, 8'h02, 8'h03};
    for (int i = 0; i < nInt; i++) begin lens.push_back(12); tasks.push_back(8'h04); end
    lens.push_back(8); tasks.push_back(8'h05);
    idx = 0;
    for (int s = 0; s < lens.size(); s++) begin
      for (int b = 0; b < lens[s]; b++) begin
        expQ.push_back({A_BUF, payByte(base, idx)});
        idx++;
      end
      expQ.push_back({A_CMD, tasks[s]});
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic runFrame(input int nInt, input bit inv, input bit sym, input bit injS,
                          input int errAtI, input bit finBadI, input logic [3:0] idleS,
                          input int expCode);
    int waitCyc;
    int mis;
    int n;
    cfgInvert = inv; cfgSymIrq = sym; numInter = 8'(nInt);
    cfgClkDiv = 8'($urandom_range(1, 255)); payBase = 8'($urandom_range(0, 255));
    injSym = injS; errAt = errAtI; finBad = finBadI; idleStat = idleS;
    buildExp(nInt, inv, sym, cfgClkDiv, payBase);
    @(negedge clk) mdlClr = 1'b1;
    @(negedge clk) begin mdlClr = 1'b0; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    waitCyc = 0;
    while (!done && !error && waitCyc < 60000) begin
      @(negedge clk);
      waitCyc++;
    end
    if (waitCyc >= 60000) begin
      chk(1'b0, "R6", "watchdog expired waiting for done/error", waitCyc, 60000);
      finishRun();
    end
    mis = -1;
    n = (logQ.size() < expQ.size()) ? logQ.size() : expQ.size();
    for (int i = 0; i < n; i++) if (mis < 0 && logQ[i] != expQ[i]) mis = i;
    if (expCode == 0) begin
      chk(done && !error, "R6", "frame completes without error", {done, error}, 2);
      chk(tickCnt == 18, "R9", "symbol ticks at done", tickCnt, 18);
      chk(logQ.size() >= 2 && logQ[0] == expQ[0] && logQ[1] == expQ[1], "R1",
          "mode/control writes", (logQ.size() >= 2) ? logQ[0] : 0, expQ[0]);
      chk(logQ.size() == expQ.size(), "R5", "bus write count", logQ.size(), expQ.size());
      chk(mis < 0, "R3", "bus write content",
          (mis < 0) ? 0 : logQ[mis], (mis < 0) ? 0 : expQ[mis]);
      chk(gapViol == 0, "R4", "command directly after buffer write", gapViol, 0);
      if (injS) chk(done && !error, "R7", "symbol-ready interrupts skipped", error, 0);
    end else begin
      chk(error && !done, "R10", "error flag raised", {error, done}, 2);
      chk(int'(errCode) == expCode, (expCode == 8) ? "R8" : (expCode == 1) ? "R2" : "R10",
          "error code", errCode, expCode);
      chk(mis < 0, "R3", "writes before abort",
          (mis < 0) ? 0 : logQ[mis], (mis < 0) ? 0 : expQ[mis]);
      n = logQ.size();
      repeat (20) @(negedge clk);
      chk(logQ.size() == n && error && !regRd, "R10", "bus quiet after abort", logQ.size(), n);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h2961);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!regWr && !regRd && !srcPop, "R11", "bus strobes in reset", {regWr, regRd, srcPop}, 0);
    chk(!done && !error && errCode == 0, "R11", "flags in reset", {done, error, errCode}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!regWr && !regRd && !done && !error, "R11", "idle after reset",
        {regWr, regRd, done, error}, 0);

    // directed counts
    runFrame(0, 1'b0, 1'b0, 1'b0, -1, 1'b0, 4'b0100, 0);
    runFrame(1, 1'b1, 1'b0, 1'b0, -1, 1'b0, 4'b0100, 0);
    runFrame(255, 1'b1, 1'b0, 1'b0, -1, 1'b0, 4'b0100, 0);
    // symbol-ready interrupts ahead of every acknowledge (R7)
    runFrame(2, 1'b0, 1'b1, 1'b1, -1, 1'b0, 4'b0100, 0);
    // random frames
    for (int f = 0; f < 5; f++) begin
      int ni;
      ni = $urandom_range(0, 4);
      runFrame(ni, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), -1, 1'b0, 4'b0100, 0);
    end
    // faults
    runFrame(1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 4'b0100, codeFor(0, 1));
    runFrame(2, 1'b0, 1'b0, 1'b0, 3, 1'b0, 4'b0100, codeFor(3, 2));
    runFrame(3, 1'b1, 1'b0, 1'b0, 5, 1'b0, 4'b0100, codeFor(5, 3));
    runFrame(2, 1'b0, 1'b0, 1'b0, 6, 1'b0, 4'b0100, codeFor(6, 2));
    runFrame(0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 4'b0100, codeFor(1, 0));
    runFrame(1, 1'b0, 1'b0, 1'b0, -1, 1'b1, 4'b0100, 8);
    runFrame(1, 1'b0, 1'b0, 1'b0, -1, 1'b0, 4'b0000, 1);
    // recovery after an abort
    runFrame(1, 1'b0, 1'b0, 1'b0, -1, 1'b0, 4'b0100, 0);
    finishRun();
  end
endmodule